// File: doc/BRIEF.md
# Timer interrupt flag and mask controller

This block gathers the event strobes of three timer/counters (overflow, compare match, input capture) into an 8-bit flag register. Next to it sits an 8-bit enable register, and a global interrupt enable input gates the whole set. Each source drives its own request line, which is high when its flag, its enable bit and the global enable are all 1. The block also reports the single most urgent enabled source to the interrupt controller as a valid/id pair.

A flag is cleared in one of two ways. The CPU can acknowledge that source's vector, or software can write a 1 to the flag's position through the bus port. Both registers can always be read on their own output ports.

For the two overflow sources, a per-timer mode input picks which strobe sets the flag. In normal mode the wrap strobe sets it. In PWM mode the leave-zero strobe sets it instead; that strobe is produced on the cycle the counter goes from zero to one.

The request stream follows these rules:
- `irq_vld_o` stays high and `irq_id_o` holds while the chosen source is pending.
- The id changes only when a more urgent source becomes pending, or when the current one is acknowledged or masked off.
- There is no ready: the acknowledge input plays that role, and it names exactly one source.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, the flag register, the enable register, all request lines and `irq_vld_o` are 0, and `irq_id_o` is 0.
- R2: An effective event on bit i sets flag i at the next clock edge, whatever the enable bits or `gie_i` hold. A flag never rises without such an event.
- R3: A bus write with `wr_sel_i`=0 clears every flag whose data bit is 1. A 0 data bit leaves that flag unchanged, and the enable register is not changed.
- R4: `ack_vld_i` with `ack_id_i`=k clears flag k only, at the next edge. No flag falls except by R3 or R4.
- R5: When an event and a clear hit the same bit in the same cycle, the flag ends up 1.
- R6: `irq_o[i]` is 1 exactly when `gie_i`, enable bit i and flag i are all 1.
- R7: A bus write with `wr_sel_i`=1 loads the enable register from `wr_data_i` and leaves the flags unchanged. The enable bit positions match the flag bit positions.
- R8: Flag bits, from 7 down to 0, are: timer1 overflow, timer1 compare A, timer1 compare B, timer2 overflow, timer1 capture, timer2 compare, timer0 overflow, timer0 compare. `irq_vld_o` is 1 when any request line is high. `irq_id_o` is then the bit position of the first high request in the order 7, 6, 5, 3, 4, 2, 1, 0.
- R9: Each overflow source has a mode bit: `pwm_i[1]` for timer1, which drives bit 7, and `pwm_i[0]` for timer2, which drives bit 4. With the mode bit at 0, `evt_i` sets that overflow bit and `leave0_i` is ignored. With the mode bit at 1, `leave0_i` sets it and `evt_i` at that position is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event strobes, one per flag bit; bits 7 and 4 are the wrap strobes |
| leave0_i | input | 2 | Leave-zero strobes: bit 1 for timer1, bit 0 for timer2 |
| pwm_i | input | 2 | PWM overflow rule select: bit 1 for timer1, bit 0 for timer2 |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Bus write strobe |
| wr_sel_i | input | 1 | Write target: 0 for flags (write one to clear), 1 for enables |
| wr_data_i | input | 8 | Bus write data |
| ack_vld_i | input | 1 | Vector acknowledge strobe |
| ack_id_i | input | 3 | Bit position of the acknowledged source |
| rd_flag_o | output | 8 | Flag register contents |
| rd_mask_o | output | 8 | Enable register contents |
| irq_o | output | 8 | Per-source interrupt requests |
| irq_vld_o | output | 1 | Some enabled source is pending |
| irq_id_o | output | 3 | Bit position of the most urgent pending source |

## Verification
Some rules are checked on every cycle:
- Flags rise only on an effective event, and every event does set its flag.
- Flags fall only through a bus clear or an acknowledge.
- No request line is high without its flag, and none is high while the global enable is low.
- The reported id always points at a high request line.

Other behaviour needs the bench's scenarios and reference model: the exact order of urgency among several pending sources, set-wins collisions, the PWM strobe swap, and the separation of enable writes from flag writes.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NSRC = 8;
  localparam int IDW  = $clog2(NSRC);
  localparam int NTMR_OVF = 2;
  // flag positions of the overflow sources, indexed by mode bit
  localparam int OVF_POS [NTMR_OVF] = '{4, 7};
  // urgency order, most urgent first
  localparam logic [IDW-1:0] PRIO_ORDER [NSRC] =
    '{3'd7, 3'd6, 3'd5, 3'd3, 3'd4, 3'd2, 3'd1, 3'd0};
  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [IDW-1:0]  src_id_t;
endpackage

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set has precedence over clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_prio_pick.sv
module tmr_prio_pick
  import tmr_irq_pkg::*;
(
  input  src_vec_t req_i,
  output logic     vld_o,
  output src_id_t  id_o
);
  always_comb begin
    vld_o = 1'b0;
    id_o  = '0;
    // walk from least urgent up so the most urgent winner is written last
    for (int r = NSRC - 1; r >= 0; r--) begin
      if (req_i[PRIO_ORDER[r]]) begin
        vld_o = 1'b1;
        id_o  = PRIO_ORDER[r];
      end
    end
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] evt_i,
  input  logic [1:0] leave0_i,
  input  logic [1:0] pwm_i,
  input  logic       gie_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       ack_vld_i,
  input  logic [2:0] ack_id_i,
  output logic [7:0] rd_flag_o,
  output logic [7:0] rd_mask_o,
  output logic [7:0] irq_o,
  output logic       irq_vld_o,
  output logic [2:0] irq_id_o
);
  src_vec_t ev_eff;
  src_vec_t clr_vec;
  src_vec_t ack_vec;
  src_vec_t flag_q;
  src_vec_t mask_q;

  // overflow strobe selection per timer
  always_comb begin
    ev_eff = evt_i;
    for (int t = 0; t < NTMR_OVF; t++) begin
      if (pwm_i[t]) ev_eff[OVF_POS[t]] = leave0_i[t];
    end
  end

  always_comb begin
    ack_vec = '0;
    if (ack_vld_i) ack_vec[ack_id_i] = 1'b1;
    clr_vec = ack_vec;
    if (wr_en_i && !wr_sel_i) clr_vec = clr_vec | wr_data_i;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    tmr_flag_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_eff[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flag_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mask_q <= '0;
    else if (wr_en_i && wr_sel_i) mask_q <= wr_data_i;
  end

  assign rd_flag_o = flag_q;
  assign rd_mask_o = mask_q;
  assign irq_o     = {NSRC{gie_i}} & mask_q & flag_q;

  tmr_prio_pick u_pick (
    .req_i (irq_o),
    .vld_o (irq_vld_o),
    .id_o  (irq_id_o)
  );
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] evt_i,
  input logic [1:0] leave0_i,
  input logic [1:0] pwm_i,
  input logic       gie_i,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic       ack_vld_i,
  input logic [2:0] ack_id_i,
  input logic [7:0] rd_flag_o,
  input logic [7:0] rd_mask_o,
  input logic [7:0] irq_o,
  input logic       irq_vld_o,
  input logic [2:0] irq_id_o
);
  logic [7:0] chk_ev;
  logic [7:0] chk_clr;
  always_comb begin
    chk_ev    = evt_i;
    chk_ev[7] = pwm_i[1] ? leave0_i[1] : evt_i[7];
    chk_ev[4] = pwm_i[0] ? leave0_i[0] : evt_i[4];
    chk_clr   = (wr_en_i && !wr_sel_i) ? wr_data_i : 8'h00;
    if (ack_vld_i) chk_clr = chk_clr | (8'h01 << ack_id_i);
  end

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_flag_o & $past(chk_ev)) == $past(chk_ev)));
  assert_no_spurious_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((rd_flag_o & ~$past(rd_flag_o)) & ~$past(chk_ev)) == 8'h00));
  assert_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(rd_flag_o) & ~rd_flag_o) & ~$past(chk_clr)) == 8'h00));
  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~(rd_flag_o & rd_mask_o)) == 8'h00);
  assert_gie_low_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (irq_o == 8'h00 && !irq_vld_o));
  assert_id_points_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vld_o |-> irq_o[irq_id_o]);
  assert_vld_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vld_o == (irq_o != 8'h00));
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk chk_i (.*);

// File: tb/tmr_irq_ctrl_tb_top.sv
module tmr_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_i;
  logic [1:0] leave0_i, pwm_i;
  logic       gie_i, wr_en_i, wr_sel_i, ack_vld_i;
  logic [7:0] wr_data_i;
  logic [2:0] ack_id_i;
  logic [7:0] rd_flag_o, rd_mask_o, irq_o;
  logic       irq_vld_o;
  logic [2:0] irq_id_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [7:0] m_flag, m_mask;

  always #4 clk = ~clk;

  tmr_irq_ctrl dut_i (.*);

  function automatic logic [7:0] eff_ev(logic [7:0] ev, logic [1:0] l0, logic [1:0] pm);
    logic [7:0] e = ev;
    if (pm[1]) e[7] = l0[1];
    if (pm[0]) e[4] = l0[0];
    return e;
  endfunction

  function automatic logic [3:0] pick(logic [7:0] req);
    logic [2:0] ord [8] = '{3'd7, 3'd6, 3'd5, 3'd3, 3'd4, 3'd2, 3'd1, 3'd0};
    for (int r = 0; r < 8; r++) if (req[ord[r]]) return {1'b1, ord[r]};
    return 4'b0000;
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [7:0] ei = {8{gie_i}} & m_mask & m_flag;
    logic [3:0] p  = pick(ei);
    cmp(tag, rd_flag_o, m_flag, "flags");
    cmp(tag, rd_mask_o, m_mask, "mask");
    cmp(tag, irq_o, ei, "irq");
    cmp(tag, irq_vld_o, p[3], "vld");
    cmp(tag, irq_id_o, p[2:0], "id");
  endtask

  task automatic step(logic [7:0] ev, logic [1:0] l0, logic [1:0] pm, logic g,
                      logic we, logic sel, logic [7:0] d, logic av, logic [2:0] aid,
                      string tag);
    logic [7:0] clr;
    evt_i = ev; leave0_i = l0; pwm_i = pm; gie_i = g;
    wr_en_i = we; wr_sel_i = sel; wr_data_i = d; ack_vld_i = av; ack_id_i = aid;
    clr = (we && !sel) ? d : 8'h00;
    if (av) clr = clr | (8'h01 << aid);
    @(posedge clk);
    m_flag = (m_flag & ~clr) | eff_ev(ev, l0, pm);
    if (we && sel) m_mask = d;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; evt_i = 0; leave0_i = 0; pwm_i = 0; gie_i = 0;
    wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0; ack_vld_i = 0; ack_id_i = 0;
    m_flag = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R2: events set flags with everything masked
    step(8'hA5, 2'b00, 2'b00, 1'b0, 0, 0, 8'h00, 0, 3'd0, "R2");
    // R7: enable write, flags untouched
    step(8'h00, 2'b00, 2'b00, 1'b1, 1, 1, 8'hFF, 0, 3'd0, "R7");
    // R6/R8: priority with bits 7,5,2,0 pending
    step(8'h00, 2'b00, 2'b00, 1'b1, 0, 0, 8'h00, 0, 3'd0, "R8");
    // R3: zero bits untouched, one bits cleared; mask stays
    step(8'h00, 2'b00, 2'b00, 1'b1, 1, 0, 8'hA0, 0, 3'd0, "R3");
    // R4: acknowledge clears only bit 2
    step(8'h00, 2'b00, 2'b00, 1'b1, 0, 0, 8'h00, 1, 3'd2, "R4");
    // R8: capture bit 3 outranks timer2 overflow bit 4
    step(8'h18, 2'b00, 2'b00, 1'b1, 0, 0, 8'h00, 0, 3'd0, "R8");
    // R5: event plus write-one and ack on the same bit
    step(8'h40, 2'b00, 2'b00, 1'b1, 1, 0, 8'h40, 0, 3'd0, "R5");
    step(8'h40, 2'b00, 2'b00, 1'b1, 0, 0, 8'h00, 1, 3'd6, "R5");
    // R9: clear all, PWM mode ignores wrap strobes
    step(8'h00, 2'b00, 2'b00, 1'b1, 1, 0, 8'hFF, 0, 3'd0, "R9");
    step(8'h90, 2'b00, 2'b11, 1'b1, 0, 0, 8'h00, 0, 3'd0, "R9");
    step(8'h00, 2'b10, 2'b11, 1'b1, 0, 0, 8'h00, 0, 3'd0, "R9");
    step(8'h00, 2'b01, 2'b00, 1'b1, 0, 0, 8'h00, 0, 3'd0, "R9");
    step(8'h00, 2'b01, 2'b01, 1'b1, 0, 0, 8'h00, 0, 3'd0, "R9");
    // R6: global enable low silences all
    step(8'h00, 2'b00, 2'b00, 1'b0, 0, 0, 8'h00, 0, 3'd0, "R6");

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] ev;
      ev = 8'h00;
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 7) == 0) ev[b] = 1'b1;
      step(ev, 2'($urandom), 2'($urandom), ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 2) == 0), 1'($urandom), 8'($urandom),
           ($urandom_range(0, 2) == 0), 3'($urandom), "R2/R3/R4/R6/R8");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule